// File: doc/BRIEF.md
# Micro-op Dispatch Stage with Credit Gating and Stall Accounting

This block sits between an in-order queue of decoded instructions and the out-of-order scheduler. Each cycle it looks at up to `MAX_W` instructions at the queue head and decides how many of them to send on. It dispatches an in-order prefix of those instructions. It stops at the first instruction that lacks a credit or does not fit in the current dispatch group. The queue pops the number of instructions reported on `dsp_count`.

Five credit pools gate dispatch: reorder-buffer entries, free physical registers, scheduler slots, load-queue entries and store-queue entries. Downstream retire, issue and free events hand credits back through the `ret_*` ports. When a cycle ends before every presented instruction has gone, exactly one stall counter is charged, following a fixed priority. A histogram records how many micro-ops went out in each cycle.

Each instruction slot carries a valid bit and three 2-bit fields: micro-op count (1 to 3), destination-register count (0 to 3) and kind. Slot i occupies bits [2i+1:2i] of `in_uops`, `in_dsts` and `in_kind`, and slot 0 is the oldest.

Top module: `dispatch_stage`

## Requirements
- R1: The dispatched instructions are always a prefix of the presented slots. Scanning starts at slot 0 and stops at the first slot that is invalid or cannot go. `dsp_count` gives the prefix length, and `dsp_uops` gives its micro-op total in the same cycle.
- R2: The effective group width is `cfg_width`, except in two cases: a value of 0 selects `DEF_W`, and a value above `MAX_W` is clamped to `MAX_W`. When more than one instruction is dispatched, their micro-op total never exceeds the effective width.
- R3: An instruction whose micro-op count exceeds the effective width may dispatch only from slot 0, and it then goes alone.
- R4: An instruction needs one reorder-buffer entry and one scheduler slot per micro-op. These are counted together with the older instructions of the same group, and it waits while either pool is short.
- R5: An instruction needs one free physical register per destination. With `PRF_REGS` = 0 the register pool is unlimited and never blocks.
- R6: Kind 2'b01 is a load and needs one load-queue entry. Kind 2'b10 is a store and needs one store-queue entry. Kinds 2'b00 and 2'b11 need neither.
- R7: A cycle whose scan stops at a valid slot increments exactly one stall counter. The first failing check decides which, in the priority order register, reorder buffer, scheduler, load queue, store queue, and last the group-width limit.
- R8: In every cycle out of reset, exactly one histogram bin is incremented, at index min(dispatched micro-ops, effective width). Bin k sits at `hist_flat[16k+15:16k]`.
- R9: Credits returned in a cycle cannot be used until the following cycle.
- R10: Synchronous active-high reset restores every pool to its configured size and clears all stall and histogram counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | $clog2(MAX_W+1) | Group width, 0 selects default |
| in_vld | input | MAX_W | Valid per head slot |
| in_uops | input | 2*MAX_W | Micro-op count per slot |
| in_dsts | input | 2*MAX_W | Destination count per slot |
| in_kind | input | 2*MAX_W | Instruction kind per slot |
| ret_rob | input | 8 | Reorder-buffer entries returned |
| ret_prf | input | 8 | Physical registers returned |
| ret_sch | input | 8 | Scheduler slots returned |
| ret_lq | input | 8 | Load-queue entries returned |
| ret_sq | input | 8 | Store-queue entries returned |
| dsp_count | output | $clog2(MAX_W+1) | Instructions dispatched this cycle |
| dsp_uops | output | $clog2(MAX_W+4) | Micro-ops dispatched this cycle |
| stl_prf | output | 16 | Cycles stalled on registers |
| stl_rob | output | 16 | Cycles stalled on reorder buffer |
| stl_sch | output | 16 | Cycles stalled on scheduler |
| stl_lq | output | 16 | Cycles stalled on load queue |
| stl_sq | output | 16 | Cycles stalled on store queue |
| stl_grp | output | 16 | Cycles stalled on group width |
| hist_flat | output | 16*(MAX_W+1) | Per-cycle micro-op histogram |

## Verification
`dsp_count` and `dsp_uops` are combinational in the same cycle as the presented slots and the current credit levels. The bench therefore drives on a falling edge and samples them 1 ns later, before the next rising edge. Stall counters, histogram bins and credit levels change on the rising edge that ends that cycle, so they are read at the following falling edge. The effect of a credit return is looked for one full cycle after the return is driven. In the cycle of the return itself, the bench expects the stall to persist.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

    localparam int CRD_W = 8;
    localparam int NSTL  = 6;

    typedef enum logic [1:0] {
        K_ALU = 2'd0,
        K_LD  = 2'd1,
        K_ST  = 2'd2,
        K_RSV = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        STL_NONE = 3'd0,
        STL_PRF  = 3'd1,
        STL_ROB  = 3'd2,
        STL_SCH  = 3'd3,
        STL_LQ   = 3'd4,
        STL_SQ   = 3'd5,
        STL_GRP  = 3'd6
    } stall_e;

    typedef struct packed {
        logic       vld;
        logic [1:0] uops;
        logic [1:0] dsts;
        kind_e      kind;
    } slot_t;

    typedef struct packed {
        logic [CRD_W-1:0] rob;
        logic [CRD_W-1:0] prf;
        logic [CRD_W-1:0] sch;
        logic [CRD_W-1:0] lq;
        logic [CRD_W-1:0] sq;
    } crd_t;

endpackage

// File: rtl/dsp_credit.sv
module dsp_credit
    import dsp_pkg::*;
#(
    parameter int MAX = 16,
    parameter bit UNL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CRD_W-1:0] take,
    input  logic [CRD_W-1:0] give,
    output logic [CRD_W-1:0] avail
);

    generate
        if (UNL) begin : g_unl
            logic unused_ok;
            assign unused_ok = ^{take, give, clk, rst};
            assign avail     = '1;
        end else begin : g_cnt
            logic [CRD_W-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst) cnt_q <= CRD_W'(MAX);
                else     cnt_q <= cnt_q - take + give;
            end

            assign avail = cnt_q;

            // R4: a pool never hands out more than it holds
            assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
                take <= cnt_q);

            // R10: returns never push a pool above its configured size
            assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
                cnt_q <= CRD_W'(MAX));
        end
    endgenerate

endmodule

// File: rtl/dsp_select.sv
module dsp_select
    import dsp_pkg::*;
#(
    parameter  int MAX_W   = 4,
    parameter  int DEF_W   = 2,
    parameter  bit PRF_UNL = 1'b0,
    localparam int WW      = $clog2(MAX_W + 1),
    localparam int USW     = $clog2(MAX_W + 4)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [WW-1:0]   cfg_w,
    input  slot_t           slots [MAX_W],
    input  crd_t            avail,
    output crd_t            used,
    output logic [WW-1:0]   n_take,
    output logic [USW-1:0]  n_uops,
    output logic [WW-1:0]   bin,
    output stall_e          reason
);

    localparam int AW = CRD_W + 1;

    logic [AW-1:0] eff_w;
    logic [AW-1:0] a_u, a_rob, a_prf, a_sch, a_lq, a_sq;
    logic [AW-1:0] nu, nd;
    logic          stop, is_ld, is_st;
    logic          ok_prf, ok_rob, ok_sch, ok_lq, ok_sq, ok_grp;
    logic [WW-1:0] take;
    stall_e        why;

    always_comb begin
        if (cfg_w == '0)                eff_w = AW'(DEF_W);
        else if (cfg_w > WW'(MAX_W))    eff_w = AW'(MAX_W);
        else                            eff_w = AW'(cfg_w);

        a_u = '0; a_rob = '0; a_prf = '0; a_sch = '0; a_lq = '0; a_sq = '0;
        nu = '0; nd = '0; is_ld = 1'b0; is_st = 1'b0;
        ok_prf = 1'b0; ok_rob = 1'b0; ok_sch = 1'b0;
        ok_lq = 1'b0; ok_sq = 1'b0; ok_grp = 1'b0;
        stop = 1'b0; take = '0; why = STL_NONE;

        for (int i = 0; i < MAX_W; i++) begin
            if (!stop) begin
                if (!slots[i].vld) begin
                    stop = 1'b1;
                end else begin
                    nu     = AW'(slots[i].uops);
                    nd     = AW'(slots[i].dsts);
                    is_ld  = (slots[i].kind == K_LD);
                    is_st  = (slots[i].kind == K_ST);
                    ok_prf = PRF_UNL || ((a_prf + nd) <= {1'b0, avail.prf});
                    ok_rob = (a_rob + nu) <= {1'b0, avail.rob};
                    ok_sch = (a_sch + nu) <= {1'b0, avail.sch};
                    ok_lq  = !is_ld || ((a_lq + AW'(1)) <= {1'b0, avail.lq});
                    ok_sq  = !is_st || ((a_sq + AW'(1)) <= {1'b0, avail.sq});
                    ok_grp = (i == 0) || ((a_u + nu) <= eff_w);
                    if (ok_prf && ok_rob && ok_sch && ok_lq && ok_sq && ok_grp) begin
                        a_u   = a_u + nu;
                        a_rob = a_rob + nu;
                        a_sch = a_sch + nu;
                        a_prf = a_prf + nd;
                        a_lq  = a_lq + AW'(is_ld);
                        a_sq  = a_sq + AW'(is_st);
                        take  = take + WW'(1);
                    end else begin
                        stop = 1'b1;
                        if      (!ok_prf) why = STL_PRF;
                        else if (!ok_rob) why = STL_ROB;
                        else if (!ok_sch) why = STL_SCH;
                        else if (!ok_lq)  why = STL_LQ;
                        else if (!ok_sq)  why = STL_SQ;
                        else              why = STL_GRP;
                    end
                end
            end
        end
    end

    assign used.rob = a_rob[CRD_W-1:0];
    assign used.prf = a_prf[CRD_W-1:0];
    assign used.sch = a_sch[CRD_W-1:0];
    assign used.lq  = a_lq[CRD_W-1:0];
    assign used.sq  = a_sq[CRD_W-1:0];
    assign n_take   = take;
    assign n_uops   = a_u[USW-1:0];
    assign bin      = (a_u > eff_w) ? eff_w[WW-1:0] : a_u[WW-1:0];
    assign reason   = why;

    // R2: multi-instruction groups stay within the effective width
    assert_group_width_R2: assert property (@(posedge clk) disable iff (rst)
        (n_take > WW'(1)) |-> (AW'(n_uops) <= eff_w));

    // R3: an oversized instruction always travels alone
    assert_oversize_alone_R3: assert property (@(posedge clk) disable iff (rst)
        (AW'(n_uops) > eff_w) |-> (n_take == WW'(1)));

endmodule

// File: rtl/dsp_stats.sv
module dsp_stats
    import dsp_pkg::*;
#(
    parameter  int MAX_W = 4,
    parameter  int SW    = 16,
    localparam int WW    = $clog2(MAX_W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  stall_e        reason,
    input  logic [WW-1:0] bin,
    output logic [SW-1:0] stl_cnt  [NSTL],
    output logic [SW-1:0] hist_cnt [MAX_W+1]
);

    logic [NSTL-1:0] stl_inc;
    logic [MAX_W:0]  hist_inc;

    genvar k;
    generate
        for (k = 0; k < NSTL; k++) begin : g_stl
            assign stl_inc[k] = (reason == stall_e'(k + 1));
            always_ff @(posedge clk) begin
                if (rst)             stl_cnt[k] <= '0;
                else if (stl_inc[k]) stl_cnt[k] <= stl_cnt[k] + SW'(1);
            end
        end
        for (k = 0; k <= MAX_W; k++) begin : g_hist
            assign hist_inc[k] = (bin == WW'(k));
            always_ff @(posedge clk) begin
                if (rst)              hist_cnt[k] <= '0;
                else if (hist_inc[k]) hist_cnt[k] <= hist_cnt[k] + SW'(1);
            end
        end
    endgenerate

    // R7: at most one stall reason is charged per cycle
    assert_one_reason_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stl_inc));

    // R8: exactly one histogram bin moves per cycle
    assert_one_bin_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot(hist_inc));

endmodule

// File: rtl/dispatch_stage.sv
module dispatch_stage
    import dsp_pkg::*;
#(
    parameter  int MAX_W    = 4,
    parameter  int DEF_W    = 2,
    parameter  int ROB_SZ   = 16,
    parameter  int PRF_REGS = 12,
    parameter  int SCH_SZ   = 8,
    parameter  int LQ_SZ    = 4,
    parameter  int SQ_SZ    = 4,
    parameter  int SW       = 16,
    localparam int WW       = $clog2(MAX_W + 1),
    localparam int USW      = $clog2(MAX_W + 4)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [WW-1:0]          cfg_width,
    input  logic [MAX_W-1:0]       in_vld,
    input  logic [2*MAX_W-1:0]     in_uops,
    input  logic [2*MAX_W-1:0]     in_dsts,
    input  logic [2*MAX_W-1:0]     in_kind,
    input  logic [CRD_W-1:0]       ret_rob,
    input  logic [CRD_W-1:0]       ret_prf,
    input  logic [CRD_W-1:0]       ret_sch,
    input  logic [CRD_W-1:0]       ret_lq,
    input  logic [CRD_W-1:0]       ret_sq,
    output logic [WW-1:0]          dsp_count,
    output logic [USW-1:0]         dsp_uops,
    output logic [SW-1:0]          stl_prf,
    output logic [SW-1:0]          stl_rob,
    output logic [SW-1:0]          stl_sch,
    output logic [SW-1:0]          stl_lq,
    output logic [SW-1:0]          stl_sq,
    output logic [SW-1:0]          stl_grp,
    output logic [SW*(MAX_W+1)-1:0] hist_flat
);

    slot_t         slots [MAX_W];
    crd_t          avail, used;
    logic [WW-1:0] bin;
    stall_e        reason;
    logic [SW-1:0] stl_cnt  [NSTL];
    logic [SW-1:0] hist_cnt [MAX_W+1];

    genvar g;
    generate
        for (g = 0; g < MAX_W; g++) begin : g_slot
            assign slots[g].vld  = in_vld[g];
            assign slots[g].uops = in_uops[2*g +: 2];
            assign slots[g].dsts = in_dsts[2*g +: 2];
            assign slots[g].kind = kind_e'(in_kind[2*g +: 2]);
        end
        for (g = 0; g <= MAX_W; g++) begin : g_hout
            assign hist_flat[g*SW +: SW] = hist_cnt[g];
        end
    endgenerate

    dsp_credit #(.MAX(ROB_SZ), .UNL(1'b0)) i_rob (
        .clk(clk), .rst(rst), .take(used.rob), .give(ret_rob), .avail(avail.rob));
    dsp_credit #(.MAX(PRF_REGS), .UNL(PRF_REGS == 0)) i_prf (
        .clk(clk), .rst(rst), .take(used.prf), .give(ret_prf), .avail(avail.prf));
    dsp_credit #(.MAX(SCH_SZ), .UNL(1'b0)) i_sch (
        .clk(clk), .rst(rst), .take(used.sch), .give(ret_sch), .avail(avail.sch));
    dsp_credit #(.MAX(LQ_SZ), .UNL(1'b0)) i_lq (
        .clk(clk), .rst(rst), .take(used.lq), .give(ret_lq), .avail(avail.lq));
    dsp_credit #(.MAX(SQ_SZ), .UNL(1'b0)) i_sq (
        .clk(clk), .rst(rst), .take(used.sq), .give(ret_sq), .avail(avail.sq));

    dsp_select #(.MAX_W(MAX_W), .DEF_W(DEF_W), .PRF_UNL(PRF_REGS == 0)) i_sel (
        .clk(clk), .rst(rst), .cfg_w(cfg_width), .slots(slots), .avail(avail),
        .used(used), .n_take(dsp_count), .n_uops(dsp_uops), .bin(bin), .reason(reason));

    dsp_stats #(.MAX_W(MAX_W), .SW(SW)) i_stats (
        .clk(clk), .rst(rst), .reason(reason), .bin(bin),
        .stl_cnt(stl_cnt), .hist_cnt(hist_cnt));

    assign stl_prf = stl_cnt[0];
    assign stl_rob = stl_cnt[1];
    assign stl_sch = stl_cnt[2];
    assign stl_lq  = stl_cnt[3];
    assign stl_sq  = stl_cnt[4];
    assign stl_grp = stl_cnt[5];

    // R7: a blocked head always carries a named reason
    assert_blocked_has_reason_R7: assert property (@(posedge clk) disable iff (rst)
        (in_vld[0] && (dsp_count == '0)) |-> (reason != STL_NONE));

    // R1: nothing dispatches when slot 0 is empty
    assert_prefix_empty_R1: assert property (@(posedge clk) disable iff (rst)
        !in_vld[0] |-> (dsp_count == '0));

endmodule

// File: tb/test_dispatch_stage.sv
`timescale 1ns/1ps
module test_dispatch_stage;
    import dsp_pkg::*;

    typedef struct packed {
        logic [2:0] cw;
        logic [3:0] vld;
        logic [7:0] uops;
        logic [7:0] dsts;
        logic [7:0] kind;
        logic [7:0] rs;
        logic [2:0] ecnt;
        logic [2:0] euops;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{3'd4, 4'hF, 8'h55, 8'h55, 8'h00, 8'd0, 3'd4, 3'd4},
        '{3'd0, 4'h7, 8'h15, 8'h00, 8'h05, 8'd0, 3'd2, 3'd2},
        '{3'd4, 4'h3, 8'h05, 8'h00, 8'h0A, 8'd0, 3'd2, 3'd2},
        '{3'd4, 4'h1, 8'h01, 8'h01, 8'h00, 8'd0, 3'd0, 3'd0},
        '{3'd4, 4'h0, 8'h00, 8'h00, 8'h00, 8'd8, 3'd0, 3'd0},
        '{3'd4, 4'h7, 8'h15, 8'h3F, 8'h15, 8'd0, 3'd2, 3'd2},
        '{3'd4, 4'h3, 8'h06, 8'h01, 8'h08, 8'd0, 3'd2, 3'd3},
        '{3'd4, 4'h3, 8'h07, 8'h00, 8'h00, 8'd0, 3'd1, 3'd3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [2:0]  cfg_width;
    logic [3:0]  in_vld;
    logic [7:0]  in_uops, in_dsts, in_kind;
    logic [7:0]  ret_rob, ret_prf, ret_sch, ret_lq, ret_sq;
    logic [2:0]  dsp_count, dsp_uops, u_count, u_uops;
    logic [15:0] stl_prf, stl_rob, stl_sch, stl_lq, stl_sq, stl_grp;
    logic [15:0] u_prf, u_rob, u_sch, u_lq, u_sq, u_grp;
    logic [79:0] hist_flat, u_hist;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    dispatch_stage i_dispatch_stage (
        .clk(clk), .rst(rst), .cfg_width(cfg_width), .in_vld(in_vld),
        .in_uops(in_uops), .in_dsts(in_dsts), .in_kind(in_kind),
        .ret_rob(ret_rob), .ret_prf(ret_prf), .ret_sch(ret_sch),
        .ret_lq(ret_lq), .ret_sq(ret_sq), .dsp_count(dsp_count),
        .dsp_uops(dsp_uops), .stl_prf(stl_prf), .stl_rob(stl_rob),
        .stl_sch(stl_sch), .stl_lq(stl_lq), .stl_sq(stl_sq),
        .stl_grp(stl_grp), .hist_flat(hist_flat));

    dispatch_stage #(.PRF_REGS(0)) i_dispatch_stage_unl (
        .clk(clk), .rst(rst), .cfg_width(cfg_width), .in_vld(in_vld),
        .in_uops(in_uops), .in_dsts(in_dsts), .in_kind(in_kind),
        .ret_rob(ret_rob), .ret_prf(ret_prf), .ret_sch(ret_sch),
        .ret_lq(ret_lq), .ret_sq(ret_sq), .dsp_count(u_count),
        .dsp_uops(u_uops), .stl_prf(u_prf), .stl_rob(u_rob),
        .stl_sch(u_sch), .stl_lq(u_lq), .stl_sq(u_sq),
        .stl_grp(u_grp), .hist_flat(u_hist));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] cw, input logic [3:0] v,
                         input logic [7:0] u, input logic [7:0] d,
                         input logic [7:0] k, input logic [7:0] rs,
                         input logic [7:0] rl);
        cfg_width = cw; in_vld = v; in_uops = u; in_dsts = d; in_kind = k;
        ret_rob = 8'd0; ret_prf = 8'd0; ret_sch = rs; ret_lq = rl; ret_sq = 8'd0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        drive(3'd4, 4'h0, 8'h00, 8'h00, 8'h00, 8'd0, 8'd0);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic int bin_of(input int k);
        return int'(hist_flat[k*16 +: 16]);
    endfunction

    initial begin : wd
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10: counters cleared by reset
        chk("R10 stl_prf after reset", int'(stl_prf), 0);
        chk("R10 stl_grp after reset", int'(stl_grp), 0);
        for (int b = 0; b < 5; b++) chk($sformatf("R10 hist bin %0d after reset", b), bin_of(b), 0);

        // Table walk: credits carried over between rows
        for (int r = 0; r < 8; r++) begin
            drive(TBL[r].cw, TBL[r].vld, TBL[r].uops, TBL[r].dsts, TBL[r].kind, TBL[r].rs, 8'd0);
            #1;
            chk($sformatf("R1 R4 R5 R6 row %0d count", r), int'(dsp_count), int'(TBL[r].ecnt));
            chk($sformatf("R2 row %0d uops", r), int'(dsp_uops), int'(TBL[r].euops));
            @(negedge clk);
        end
        // R7: one stall per blocked cycle, by priority
        chk("R7 stl_prf priority over lq", int'(stl_prf), 1);
        chk("R7 stl_rob priority over sch", int'(stl_rob), 1);
        chk("R7 stl_sch", int'(stl_sch), 1);
        chk("R7 stl_lq", int'(stl_lq), 0);
        chk("R7 stl_grp default width", int'(stl_grp), 1);
        // R8: histogram bins
        chk("R8 bin0", bin_of(0), 2);
        chk("R8 bin1", bin_of(1), 0);
        chk("R8 bin2", bin_of(2), 3);
        chk("R8 bin3", bin_of(3), 2);
        chk("R8 bin4", bin_of(4), 1);

        // R10: pools restored (reorder buffer and load queue were empty)
        do_reset();
        drive(3'd4, 4'h1, 8'h01, 8'h00, 8'h01, 8'd0, 8'd0);
        #1 chk("R10 load dispatches after reset", int'(dsp_count), 1);
        @(negedge clk);

        // R3: oversized instruction goes alone from slot 0
        do_reset();
        drive(3'd1, 4'h3, 8'h07, 8'h00, 8'h00, 8'd0, 8'd0);
        #1;
        chk("R3 oversized count", int'(dsp_count), 1);
        chk("R3 oversized uops", int'(dsp_uops), 3);
        @(negedge clk);
        chk("R8 oversized lands in width bin", bin_of(1), 1);
        chk("R7 group stall on oversized", int'(stl_grp), 1);
        // R2: width above maximum clamps
        drive(3'd7, 4'hF, 8'h55, 8'h00, 8'h00, 8'd0, 8'd0);
        #1 chk("R2 clamped width count", int'(dsp_count), 4);
        @(negedge clk);

        // R6 and R9: load queue exhaustion and return timing
        do_reset();
        drive(3'd4, 4'hF, 8'h55, 8'h00, 8'h55, 8'd0, 8'd0);
        #1 chk("R6 four loads", int'(dsp_count), 4);
        @(negedge clk);
        drive(3'd4, 4'h1, 8'h01, 8'h00, 8'h01, 8'd0, 8'd1);
        #1 chk("R9 same-cycle return not usable", int'(dsp_count), 0);
        @(negedge clk);
        drive(3'd4, 4'h1, 8'h01, 8'h00, 8'h01, 8'd0, 8'd0);
        #1 chk("R9 return usable next cycle", int'(dsp_count), 1);
        @(negedge clk);
        chk("R7 stl_lq", int'(stl_lq), 1);

        // R6: store queue exhaustion
        do_reset();
        drive(3'd4, 4'hF, 8'h55, 8'h00, 8'hAA, 8'd0, 8'd0);
        #1 chk("R6 four stores", int'(dsp_count), 4);
        @(negedge clk);
        drive(3'd4, 4'h1, 8'h01, 8'h00, 8'h02, 8'd0, 8'd0);
        #1 chk("R6 store blocked", int'(dsp_count), 0);
        @(negedge clk);
        chk("R7 stl_sq", int'(stl_sq), 1);

        // R5: register pool, limited and unlimited
        do_reset();
        for (int c = 0; c < 4; c++) begin
            drive(3'd4, 4'h1, 8'h01, 8'h03, 8'h00, 8'd0, 8'd0);
            #1 chk($sformatf("R5 reg alloc cycle %0d", c), int'(dsp_count), 1);
            @(negedge clk);
        end
        drive(3'd4, 4'h1, 8'h01, 8'h03, 8'h00, 8'd0, 8'd0);
        #1;
        chk("R5 limited pool blocks", int'(dsp_count), 0);
        chk("R5 unlimited pool passes", int'(u_count), 1);
        @(negedge clk);
        chk("R7 stl_prf", int'(stl_prf), 1);

        drive(3'd4, 4'h0, 8'h00, 8'h00, 8'h00, 8'd0, 8'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule